// File: doc/BRIEF.md
# Idle-Gated Software Reset Controller

This block gives software a way to reset the core logic of a network controller without stalling the configuration bus. Software writes a 1 to the request bit of the reset-control register. The request stays pending until the receive and transmit DMA engines both report idle in the same cycle. Only then is a single-cycle reset pulse sent to the core logic.

Software polls the same bit to learn when the reset has happened. The bit reads 1 while the request is waiting and 0 once the pulse has gone out. A second, read-only register reports the FIFO cell depths of both directions, along with two identification constants.

Register offsets:
- The configuration register is at byte offset 0x00.
- The reset-control register is at byte offset 0x04.
- Every other offset is unmapped.

Read data is combinational on the address. Writes take effect on the rising clock edge.

Top module: `swrst_ctrl`

## Requirements
- R1: After the active-low system reset, `core_rst` is 0 and the reset-control register (offset 0x04) reads 0x00000000.
- R2: In the reset-control register, bits 31..1 always read 0, whatever data was written.
- R3: A write to offset 0x04 with `wr_data[0]`=1 sets the request bit on that clock edge, so the register reads 1 after the edge.
- R4: A write to offset 0x04 with `wr_data[0]`=0 leaves the request bit unchanged.
- R5: While a request is pending and either `rx_idle` or `tx_idle` is 0, no pulse is issued and the request bit keeps reading 1.
- R6: On the first edge at which a request is pending and both idle inputs are 1, `core_rst` goes high for exactly one clock cycle, and the request bit reads 0 from that same edge on.
- R7: A write of 1 while a request is already pending (including in the firing cycle) is absorbed, so one request yields exactly one pulse.
- R8: Offset 0x00 always reads 0x03030101: transmit cell depth in bits 31..24, receive cell depth in bits 23..16, address type in bits 15..8, configuration value in bits 7..0. Writes to it have no effect.
- R9: Reads from any offset other than 0x00 and 0x04 return 0, and writes to such offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| rx_idle | input | 1 | Receive DMA reports idle |
| tx_idle | input | 1 | Transmit DMA reports idle |
| core_rst | output | 1 | One-cycle reset pulse to the core logic |

## Verification
The bench holds a request pending through every combination of idle inputs in which at least one is low. A design that ignored one of the two idle inputs would pulse early there.

It also writes 1 again while a request is pending, including on the firing cycle itself. A design that did not absorb the repeat would emit a second pulse.

It checks that the pulse falls after one cycle and that the request bit clears on the same edge the pulse rises. It also confirms that writes of 0, writes to the read-only register and writes to unmapped offsets leave the visible state untouched. Finally, it applies the system reset with a request pending, to prove that only that reset can discard one.

// File: rtl/swrst_ctrl.sv
module swrst_ctrl #(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  CFG_OFS  = 8'h00,
  parameter logic [7:0]  CTL_OFS  = 8'h04,
  parameter logic [7:0]  TX_CELLS = 8'd3,
  parameter logic [7:0]  RX_CELLS = 8'd3,
  parameter logic [7:0]  ADR_KIND = 8'd1,
  parameter logic [7:0]  CFG_VAL  = 8'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              rx_idle,
  input  logic              tx_idle,
  output logic              core_rst
);
  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_OFS);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_OFS);
  localparam logic [31:0] CFG_WORD = {TX_CELLS, RX_CELLS, ADR_KIND, CFG_VAL};

  logic pend_q;
  logic fire;
  logic req_wr;

  assign req_wr = wr_en && (addr == CTL_A) && wr_data[0];
  assign fire   = pend_q && rx_idle && tx_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      core_rst <= 1'b0;
    end else begin
      core_rst <= fire;
      if (pend_q) pend_q <= !fire;
      else        pend_q <= req_wr;
    end
  end

  assign rd_data = (addr == CFG_A) ? CFG_WORD :
                   (addr == CTL_A) ? {31'b0, pend_q} : 32'b0;
endmodule

module swrst_ctrl_chk #(
  parameter int         ADDR_W  = 8,
  parameter logic [7:0] CFG_OFS = 8'h00,
  parameter logic [7:0] CTL_OFS = 8'h04
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [31:0]       wr_data,
  input logic [31:0]       rd_data,
  input logic              rx_idle,
  input logic              tx_idle,
  input logic              core_rst,
  input logic              pend_q
);
  logic hit_ctl;
  assign hit_ctl = (addr == ADDR_W'(CTL_OFS));

  // R6: pulse is one cycle wide
  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> !core_rst);
  // R6: the pending bit clears on the edge the pulse rises
  a_r6_clear_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst) |-> !pend_q && $past(pend_q));
  // R5: a pulse needs both idle inputs high on the previous cycle
  a_r5_idle_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !(rx_idle && tx_idle)) |=> pend_q && !core_rst);
  // R3: a write of 1 leaves the request pending or fires it
  a_r3_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_ctl && wr_data[0]) |=> (pend_q || core_rst));
  // R4: nothing sets the pending bit except a write of 1
  a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !(wr_en && hit_ctl && wr_data[0])) |=> !pend_q);
  // R2: reserved bits read 0
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ctl |-> rd_data[31:1] == 31'b0);
  // R8: configuration word is constant
  a_r8_cfg_const: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(CFG_OFS)) |-> rd_data == 32'h0303_0101);
endmodule

bind swrst_ctrl swrst_ctrl_chk #(.ADDR_W(ADDR_W), .CFG_OFS(CFG_OFS), .CTL_OFS(CTL_OFS)) chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .rx_idle(rx_idle), .tx_idle(tx_idle), .core_rst(core_rst),
  .pend_q(pend_q));

// File: tb/swrst_ctrl_test.sv
module swrst_ctrl_test;
  localparam int PERIOD = 10;
  localparam int NV = 17;

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [31:0] d;
    logic        rx;
    logic        tx;
    logic [31:0] exp_rd;
    logic        exp_rst;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h04, 32'h0,          1'b1, 1'b1, 32'h0,          1'b0}, // R1
    '{1'b1, 8'h04, 32'hFFFF_FFFE,  1'b1, 1'b1, 32'h0,          1'b0}, // R4
    '{1'b1, 8'h04, 32'hFFFF_FFFF,  1'b0, 1'b1, 32'h1,          1'b0}, // R3 R2
    '{1'b0, 8'h04, 32'h0,          1'b0, 1'b1, 32'h1,          1'b0}, // R5
    '{1'b0, 8'h04, 32'h0,          1'b1, 1'b0, 32'h1,          1'b0}, // R5
    '{1'b0, 8'h04, 32'h0,          1'b0, 1'b0, 32'h1,          1'b0}, // R5
    '{1'b1, 8'h04, 32'h1,          1'b1, 1'b0, 32'h1,          1'b0}, // R7
    '{1'b0, 8'h04, 32'h0,          1'b1, 1'b1, 32'h0,          1'b1}, // R6
    '{1'b0, 8'h04, 32'h0,          1'b1, 1'b1, 32'h0,          1'b0}, // R6 R7
    '{1'b0, 8'h00, 32'h0,          1'b1, 1'b1, 32'h0303_0101,  1'b0}, // R8
    '{1'b1, 8'h00, 32'h0,          1'b1, 1'b1, 32'h0303_0101,  1'b0}, // R8
    '{1'b0, 8'h08, 32'h0,          1'b1, 1'b1, 32'h0,          1'b0}, // R9
    '{1'b1, 8'h08, 32'hFFFF_FFFF,  1'b1, 1'b1, 32'h0,          1'b0}, // R9
    '{1'b0, 8'h04, 32'h0,          1'b1, 1'b1, 32'h0,          1'b0}, // R9
    '{1'b1, 8'h04, 32'h1,          1'b1, 1'b1, 32'h1,          1'b0}, // R3
    '{1'b1, 8'h04, 32'h1,          1'b1, 1'b1, 32'h0,          1'b1}, // R7
    '{1'b0, 8'h04, 32'h0,          1'b1, 1'b1, 32'h0,          1'b0}  // R7
  };
  localparam string TAG [NV] = '{"R1","R4","R3","R5","R5","R5","R7","R6","R6",
                                 "R8","R8","R9","R9","R9","R3","R7","R7"};

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        rx_idle, tx_idle;
  logic        core_rst;
  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  swrst_ctrl uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .rx_idle(rx_idle), .tx_idle(tx_idle), .core_rst(core_rst));

  task automatic check(input string tag, input logic [31:0] rd_exp, input logic rst_exp);
    checks++;
    if (rd_data !== rd_exp || core_rst !== rst_exp) begin
      errors++;
      $display("FAIL %s: rd_data=%h core_rst=%b expected rd_data=%h core_rst=%b",
               tag, rd_data, core_rst, rd_exp, rst_exp);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic rx, input logic tx);
    @(negedge clk);
    wr_en = w; addr = a; wr_data = d; rx_idle = rx; tx_idle = tx;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = 8'h04; wr_data = '0; rx_idle = 1'b1; tx_idle = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", 32'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].wr, VEC[i].a, VEC[i].d, VEC[i].rx, VEC[i].tx);
      check(TAG[i], VEC[i].exp_rd, VEC[i].exp_rst);
    end

    // R5: long wait with one engine busy never pulses
    step(1'b1, 8'h04, 32'h1, 1'b0, 1'b1);
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 8'h04, 32'h0, (i % 2) == 0, (i % 2) == 1);
      check("R5", 32'h1, 1'b0);
    end

    // R1: system reset discards a pending request
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check("R1", 32'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 8'h04, 32'h0, 1'b1, 1'b1);
    check("R1", 32'h0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule